// File: doc/BRIEF.md
# AXI Transaction Latency Monitor

This block sits beside an AXI port and watches it without driving anything. For each read and each write it measures how many clock cycles pass between a chosen start event on the address channel and a chosen end event on the data channel. For every completed transaction it adds that latency to a running total and increments a transaction count. Reads and writes have separate totals and counts. A free-running cycle counter provides the timestamps and is also visible at the ports.

Each direction has its own start selection and end selection. The start event is either the first cycle a request is presented or the cycle the request is accepted. The end event is either the first data beat or the last data beat. An optional filter compares the request ID against a match value under a mask. When the filter is on, only matching transactions add to the metrics. Up to four requests per direction may be outstanding. Completions are assumed to return in request order.

Top module: `axi_lat_mon`

## Requirements
- R1: With `cfg_rd_start_hs`=0, read timing starts in the first cycle `ar_valid` is high, and it is not restarted while the request waits for `ar_ready`. With `cfg_rd_start_hs`=1, read timing starts in the cycle where `ar_valid` and `ar_ready` are both high.
- R2: With `cfg_wr_start_hs`=0, write timing starts in the first cycle `aw_valid` is high. With `cfg_wr_start_hs`=1, it starts on the `aw_valid`/`aw_ready` handshake.
- R3: With `cfg_rd_end_first`=1, a read ends on its first `r_valid`&`r_ready` beat. With `cfg_rd_end_first`=0, it ends on the beat that carries `r_last`.
- R4: With `cfg_wr_end_first`=1, a write ends on its first `w_valid`&`w_ready` beat after the address. With `cfg_wr_end_first`=0, it ends on the beat that carries `w_last`.
- R5: Each counted completion adds (cycle count at end − cycle count at start) to the 32-bit total of its direction and adds 1 to the count of that direction. Both registers wrap modulo 2^32. At most one completion is counted per direction per cycle.
- R6: With `cfg_id_filt_en`=1, a transaction counts only if ((request ID XOR `cfg_id_match`) AND `cfg_id_mask`) is zero. A non-matching transaction leaves the total and the count unchanged. With `cfg_id_filt_en`=0, the ID has no effect.
- R7: With `cfg_met_en`=0, all totals and counts hold their values, even when transactions complete.
- R8: `cfg_met_clr`=1 sets all totals and counts to zero on the next edge. It has priority over `cfg_met_en`.
- R9: The cycle counter increments by 1 on each edge while `cfg_gclk_en`=1 and holds while `cfg_gclk_en`=0. `cfg_gclk_clr`=1 zeroes it and has priority over the enable.
- R10: Each direction can hold 4 pending start times. A start that arrives while all 4 are pending is dropped. An end event with no pending start is ignored.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_met_en | input | 1 | Enables updates of totals and counts |
| cfg_met_clr | input | 1 | Clears totals and counts |
| cfg_gclk_en | input | 1 | Enables the cycle counter |
| cfg_gclk_clr | input | 1 | Clears the cycle counter |
| cfg_rd_start_hs | input | 1 | Read start: 0 first presentation, 1 handshake |
| cfg_rd_end_first | input | 1 | Read end: 1 first beat, 0 last beat |
| cfg_wr_start_hs | input | 1 | Write start: 0 first presentation, 1 handshake |
| cfg_wr_end_first | input | 1 | Write end: 1 first beat, 0 last beat |
| cfg_id_filt_en | input | 1 | Enables ID filtering |
| cfg_id_match | input | ID_W | ID match value |
| cfg_id_mask | input | ID_W | ID mask, 1 = bit compared |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | ID_W | Read address ID |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_last | input | 1 | Last read beat |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | ID_W | Write address ID |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_last | input | 1 | Last write beat |
| gclk_count | output | 32 | Free-running cycle counter |
| rd_lat_total | output | 32 | Sum of read latencies |
| rd_txn_count | output | 32 | Number of counted reads |
| wr_lat_total | output | 32 | Sum of write latencies |
| wr_txn_count | output | 32 | Number of counted writes |

## Verification
Every latency test uses the same burst shape: the address waits some cycles for ready, then a gap, then several data beats. That shape is run under each start and end setting. Because the shape is fixed, an expected latency that differs by exactly the address wait isolates the start selection, and one that differs by exactly the beat count minus one isolates the end selection. Matching and non-matching IDs separate filter behaviour from the plain unfiltered path. A burst of five back-to-back accepted requests followed by five single-beat responses shows that the fifth start is dropped and that the surplus end event is ignored. Separate runs with metrics disabled and with the clear asserted show that the totals hold and zero.

// File: rtl/axi_lat_mon_pkg.sv
package axi_lat_mon_pkg;
    parameter int unsigned TS_W = 32;

    typedef struct packed {
        logic            keep;
        logic [TS_W-1:0] ts;
    } ts_entry_t;
endpackage

// File: rtl/lat_ts_fifo.sv
module lat_ts_fifo
    import axi_lat_mon_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  ts_entry_t push_data,
    input  logic      pop,
    output ts_entry_t head,
    output logic      empty,
    output logic      full
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        ts_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]         wp;
        logic [PW-1:0]         rp;
        logic [CW-1:0]         cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic push_ok, pop_ok;

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign head  = st_q.mem[st_q.rp];

    always_comb begin
        st_d    = st_q;
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        if (push_ok) begin
            st_d.mem[st_q.wp] = push_data;
            st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + PW'(1);
        end
        if (pop_ok) begin
            st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + PW'(1);
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10: occupancy never exceeds the number of slots
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R10: a start offered while full is dropped, so occupancy stays full
    a_r10_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);
endmodule

// File: rtl/lat_channel.sv
module lat_channel
    import axi_lat_mon_pkg::*;
#(
    parameter int unsigned ID_W  = 4,
    parameter int unsigned DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_hs,
    input  logic            end_first,
    input  logic            met_en,
    input  logic            met_clr,
    input  logic            id_filt_en,
    input  logic [ID_W-1:0] id_match,
    input  logic [ID_W-1:0] id_mask,
    input  logic            a_valid,
    input  logic            a_ready,
    input  logic [ID_W-1:0] a_id,
    input  logic            d_valid,
    input  logic            d_ready,
    input  logic            d_last,
    input  logic [TS_W-1:0] now,
    output logic [TS_W-1:0] lat_total,
    output logic [TS_W-1:0] txn_count
);
    typedef struct packed {
        logic            a_wait;
        logic            d_mid;
        logic [TS_W-1:0] total;
        logic [TS_W-1:0] count;
    } chan_st_t;

    chan_st_t  st_d, st_q;
    logic      a_hs, d_hs, start_ev, end_ev, id_ok, done;
    logic      f_empty, f_full;
    ts_entry_t f_head, f_in;
    logic [TS_W-1:0] lat;

    lat_ts_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (start_ev),
        .push_data (f_in),
        .pop       (end_ev),
        .head      (f_head),
        .empty     (f_empty),
        .full      (f_full)
    );

    always_comb begin
        st_d     = st_q;
        a_hs     = a_valid && a_ready;
        d_hs     = d_valid && d_ready;
        start_ev = start_hs ? a_hs : (a_valid && !st_q.a_wait);
        id_ok    = !id_filt_en || (((a_id ^ id_match) & id_mask) == '0);
        f_in     = '{keep: id_ok, ts: now};
        end_ev   = end_first ? (d_hs && !st_q.d_mid) : (d_hs && d_last);
        done     = end_ev && !f_empty;
        lat      = now - f_head.ts;

        st_d.a_wait = a_valid && !a_ready;
        if (d_hs) st_d.d_mid = !d_last;

        if (met_clr) begin
            st_d.total = '0;
            st_d.count = '0;
        end else if (met_en && done && f_head.keep) begin
            st_d.total = st_q.total + lat;
            st_d.count = st_q.count + TS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lat_total = st_q.total;
    assign txn_count = st_q.count;

    // R7: disabled metrics hold
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!met_en && !met_clr) |=> (st_q.count == $past(st_q.count) &&
                                   st_q.total == $past(st_q.total)));

    // R8: clear zeroes totals and counts on the next edge
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        met_clr |=> (st_q.count == '0 && st_q.total == '0));

    // R5: the count moves by at most one per cycle
    a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.count != $past(st_q.count)) |->
            (st_q.count == $past(st_q.count) + TS_W'(1) || st_q.count == '0));
endmodule

// File: rtl/gclk_counter.sv
module gclk_counter
    import axi_lat_mon_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            clr,
    output logic [TS_W-1:0] count
);
    typedef struct packed {
        logic [TS_W-1:0] cnt;
    } gc_st_t;

    gc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)     st_d.cnt = '0;
        else if (en) st_d.cnt = st_q.cnt + TS_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    // R9: clear has priority
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // R9: one step per enabled cycle
    a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> (count == $past(count) + TS_W'(1)));

    // R9: holds while disabled
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(count));
endmodule

// File: rtl/axi_lat_mon.sv
module axi_lat_mon
    import axi_lat_mon_pkg::*;
#(
    parameter int unsigned ID_W  = 4,
    parameter int unsigned DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_met_en,
    input  logic            cfg_met_clr,
    input  logic            cfg_gclk_en,
    input  logic            cfg_gclk_clr,
    input  logic            cfg_rd_start_hs,
    input  logic            cfg_rd_end_first,
    input  logic            cfg_wr_start_hs,
    input  logic            cfg_wr_end_first,
    input  logic            cfg_id_filt_en,
    input  logic [ID_W-1:0] cfg_id_match,
    input  logic [ID_W-1:0] cfg_id_mask,
    input  logic            ar_valid,
    input  logic            ar_ready,
    input  logic [ID_W-1:0] ar_id,
    input  logic            r_valid,
    input  logic            r_ready,
    input  logic            r_last,
    input  logic            aw_valid,
    input  logic            aw_ready,
    input  logic [ID_W-1:0] aw_id,
    input  logic            w_valid,
    input  logic            w_ready,
    input  logic            w_last,
    output logic [TS_W-1:0] gclk_count,
    output logic [TS_W-1:0] rd_lat_total,
    output logic [TS_W-1:0] rd_txn_count,
    output logic [TS_W-1:0] wr_lat_total,
    output logic [TS_W-1:0] wr_txn_count
);
    gclk_counter u_gclk (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg_gclk_en),
        .clr   (cfg_gclk_clr),
        .count (gclk_count)
    );

    lat_channel #(.ID_W(ID_W), .DEPTH(DEPTH)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_hs   (cfg_rd_start_hs),
        .end_first  (cfg_rd_end_first),
        .met_en     (cfg_met_en),
        .met_clr    (cfg_met_clr),
        .id_filt_en (cfg_id_filt_en),
        .id_match   (cfg_id_match),
        .id_mask    (cfg_id_mask),
        .a_valid    (ar_valid),
        .a_ready    (ar_ready),
        .a_id       (ar_id),
        .d_valid    (r_valid),
        .d_ready    (r_ready),
        .d_last     (r_last),
        .now        (gclk_count),
        .lat_total  (rd_lat_total),
        .txn_count  (rd_txn_count)
    );

    lat_channel #(.ID_W(ID_W), .DEPTH(DEPTH)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_hs   (cfg_wr_start_hs),
        .end_first  (cfg_wr_end_first),
        .met_en     (cfg_met_en),
        .met_clr    (cfg_met_clr),
        .id_filt_en (cfg_id_filt_en),
        .id_match   (cfg_id_match),
        .id_mask    (cfg_id_mask),
        .a_valid    (aw_valid),
        .a_ready    (aw_ready),
        .a_id       (aw_id),
        .d_valid    (w_valid),
        .d_ready    (w_ready),
        .d_last     (w_last),
        .now        (gclk_count),
        .lat_total  (wr_lat_total),
        .txn_count  (wr_txn_count)
    );
endmodule

// File: tb/tb_axi_lat_mon.sv
`timescale 1ns/1ps
module tb_axi_lat_mon;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_met_en = 0, cfg_met_clr = 0, cfg_gclk_en = 0, cfg_gclk_clr = 0;
    logic cfg_rd_start_hs = 0, cfg_rd_end_first = 0, cfg_wr_start_hs = 0, cfg_wr_end_first = 0;
    logic cfg_id_filt_en = 0;
    logic [3:0] cfg_id_match = '0, cfg_id_mask = '0;
    logic ar_valid = 0, ar_ready = 0, r_valid = 0, r_ready = 0, r_last = 0;
    logic aw_valid = 0, aw_ready = 0, w_valid = 0, w_ready = 0, w_last = 0;
    logic [3:0] ar_id = '0, aw_id = '0;
    logic [31:0] gclk_count, rd_lat_total, rd_txn_count, wr_lat_total, wr_txn_count;

    int n_chk = 0, n_err = 0;
    bit done = 0;
    int unsigned rd_q[$], wr_q[$];
    string rd_tq[$], wr_tq[$];
    logic [31:0] rd_pc = 0, rd_pt = 0, wr_pc = 0, wr_pt = 0;

    always #10 clk = ~clk;

    axi_lat_mon dut (.*);

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // monitor: pop expected latency on each count increment
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_txn_count == rd_pc + 32'd1) begin
                if (rd_q.size() == 0) chk(0, "R5", "unexpected read completion", rd_txn_count, rd_pc);
                else chk((rd_lat_total - rd_pt) == rd_q[0], rd_tq[0], "read latency",
                         rd_lat_total - rd_pt, rd_q[0]);
                if (rd_q.size() != 0) begin void'(rd_q.pop_front()); void'(rd_tq.pop_front()); end
            end
            if (wr_txn_count == wr_pc + 32'd1) begin
                if (wr_q.size() == 0) chk(0, "R5", "unexpected write completion", wr_txn_count, wr_pc);
                else chk((wr_lat_total - wr_pt) == wr_q[0], wr_tq[0], "write latency",
                         wr_lat_total - wr_pt, wr_q[0]);
                if (wr_q.size() != 0) begin void'(wr_q.pop_front()); void'(wr_tq.pop_front()); end
            end
        end
        rd_pc = rd_txn_count; rd_pt = rd_lat_total;
        wr_pc = wr_txn_count; wr_pt = wr_lat_total;
    end

    function automatic bit id_keep(input logic [3:0] id);
        return !cfg_id_filt_en || (((id ^ cfg_id_match) & cfg_id_mask) == 4'd0);
    endfunction

    task automatic rd_txn(input int wa, input int g, input int nb,
                          input logic [3:0] id, input string tag);
        int lat;
        lat = (cfg_rd_end_first ? wa + g : wa + g + nb - 1) - (cfg_rd_start_hs ? wa : 0);
        if (id_keep(id) && cfg_met_en) begin rd_q.push_back(lat); rd_tq.push_back(tag); end
        @(negedge clk);
        ar_valid = 1; ar_id = id; ar_ready = (wa == 0);
        for (int i = 0; i < wa; i++) begin
            @(negedge clk);
            if (i == wa - 1) ar_ready = 1;
        end
        @(negedge clk);
        ar_valid = 0; ar_ready = 0;
        for (int i = 1; i < g; i++) @(negedge clk);
        for (int b = 0; b < nb; b++) begin
            r_valid = 1; r_ready = 1; r_last = (b == nb - 1);
            @(negedge clk);
        end
        r_valid = 0; r_ready = 0; r_last = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr_txn(input int wa, input int g, input int nb,
                          input logic [3:0] id, input string tag);
        int lat;
        lat = (cfg_wr_end_first ? wa + g : wa + g + nb - 1) - (cfg_wr_start_hs ? wa : 0);
        if (id_keep(id) && cfg_met_en) begin wr_q.push_back(lat); wr_tq.push_back(tag); end
        @(negedge clk);
        aw_valid = 1; aw_id = id; aw_ready = (wa == 0);
        for (int i = 0; i < wa; i++) begin
            @(negedge clk);
            if (i == wa - 1) aw_ready = 1;
        end
        @(negedge clk);
        aw_valid = 0; aw_ready = 0;
        for (int i = 1; i < g; i++) @(negedge clk);
        for (int b = 0; b < nb; b++) begin
            w_valid = 1; w_ready = 1; w_last = (b == nb - 1);
            @(negedge clk);
        end
        w_valid = 0; w_ready = 0; w_last = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] a, b, c0, t0;
        repeat (3) @(negedge clk);
        chk(gclk_count == 0 && rd_lat_total == 0 && rd_txn_count == 0 &&
            wr_lat_total == 0 && wr_txn_count == 0, "R11", "outputs in reset",
            gclk_count | rd_lat_total | rd_txn_count | wr_lat_total | wr_txn_count, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(gclk_count == 0, "R9", "counter holds when disabled", gclk_count, 0);

        cfg_gclk_en = 1;
        @(negedge clk); a = gclk_count;
        repeat (10) @(negedge clk); b = gclk_count;
        chk((b - a) == 10, "R9", "counter steps once per cycle", b - a, 10);
        cfg_gclk_clr = 1;
        @(negedge clk);
        chk(gclk_count == 0, "R9", "clear beats enable", gclk_count, 0);
        cfg_gclk_clr = 0;

        cfg_met_en = 1;
        // read start/end selections, R1 and R3
        rd_txn(2, 3, 4, 4'h0, "R1 issue start, R3 last beat");
        cfg_rd_start_hs = 1;
        rd_txn(2, 3, 4, 4'h0, "R1 handshake start");
        cfg_rd_end_first = 1;
        rd_txn(2, 3, 4, 4'h0, "R3 first beat end");
        cfg_rd_start_hs = 0;
        rd_txn(3, 1, 2, 4'h0, "R1 issue not restarted while waiting");

        // write start/end selections, R2 and R4
        wr_txn(1, 2, 3, 4'h0, "R2 issue start, R4 last beat");
        cfg_wr_start_hs = 1;
        wr_txn(1, 2, 3, 4'h0, "R2 handshake start");
        cfg_wr_end_first = 1;
        wr_txn(1, 2, 3, 4'h0, "R4 first beat end");
        cfg_wr_end_first = 0;
        wr_txn(0, 1, 1, 4'h0, "R4 single beat");

        // ID filter, R6
        cfg_id_filt_en = 1; cfg_id_match = 4'b1010; cfg_id_mask = 4'b1100;
        rd_txn(1, 2, 2, 4'b1011, "R6 matching read");
        c0 = rd_txn_count; t0 = rd_lat_total;
        rd_txn(1, 2, 2, 4'b0110, "R6 filtered read");
        chk(rd_txn_count == c0 && rd_lat_total == t0, "R6", "filtered read not counted",
            rd_txn_count - c0, 0);
        c0 = wr_txn_count;
        wr_txn(1, 2, 2, 4'b0010, "R6 filtered write");
        chk(wr_txn_count == c0, "R6", "filtered write not counted", wr_txn_count - c0, 0);
        cfg_id_filt_en = 0;
        rd_txn(1, 2, 2, 4'b0110, "R6 filter off ignores id");

        // metrics disabled, R7
        cfg_met_en = 0;
        c0 = rd_txn_count; t0 = rd_lat_total;
        rd_txn(1, 2, 2, 4'h0, "R7");
        chk(rd_txn_count == c0 && rd_lat_total == t0, "R7", "read metrics held",
            rd_lat_total, t0);
        c0 = wr_txn_count;
        wr_txn(1, 2, 2, 4'h0, "R7");
        chk(wr_txn_count == c0, "R7", "write metrics held", wr_txn_count, c0);

        // clear with enable on, R8
        cfg_met_en = 1; cfg_met_clr = 1;
        @(negedge clk);
        cfg_met_clr = 0;
        chk(rd_lat_total == 0 && rd_txn_count == 0 && wr_lat_total == 0 && wr_txn_count == 0,
            "R8", "clear zeroes metrics", rd_lat_total | rd_txn_count | wr_lat_total | wr_txn_count, 0);

        // five outstanding reads, four slots, R10
        cfg_rd_start_hs = 0; cfg_rd_end_first = 0;
        for (int k = 0; k < 4; k++) begin rd_q.push_back(5); rd_tq.push_back("R10 queued read"); end
        c0 = rd_txn_count;
        ar_valid = 1; ar_ready = 1; ar_id = 4'h0;
        repeat (5) @(negedge clk);
        ar_valid = 0; ar_ready = 0;
        r_valid = 1; r_ready = 1; r_last = 1;
        repeat (5) @(negedge clk);
        r_valid = 0; r_ready = 0; r_last = 0;
        repeat (3) @(negedge clk);
        chk(rd_txn_count - c0 == 4, "R10", "fifth start dropped", rd_txn_count - c0, 4);

        chk(rd_q.size() == 0 && wr_q.size() == 0, "R5", "all expected completions seen",
            rd_q.size() + wr_q.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule